// File: doc/BRIEF.md
# SPI Master with Prescaled Serial Clock

This block is an SPI master that runs entirely from a fast peripheral clock and produces its serial clock through a programmable divider. Software writes a byte to the data register. That write starts an 8-bit full-duplex exchange with idle-low clock polarity and trailing-edge sampling. Outgoing bits are launched on each rising SCK edge, and incoming bits are captured on each falling edge.

When the last SCK cycle has fully ended, a done flag comes up in the status register and the received byte can be read back. Every SCK edge, including the first one, falls on a peripheral-clock edge, so every latency is counted in peripheral clocks. The divider value is sanitised when it is written: it is forced even and never below the minimum.

Slave select is a plain software-controlled output bit. The register map has four entries:

- Address 0: data.
- Address 1: status.
- Address 2: divider.
- Address 3: control.

Reads are combinational on `reg_rdata` whenever `reg_addr` is presented. Side effects of a read (arming and clearing) take place at the clock edge where `reg_rd` is high.

The sequencer is built around three states:

- `ST_IDLE` waits for a data write.
- `ST_HIGH` holds SCK high for half the divider.
- `ST_LOW` holds SCK low for half the divider.

It has four transitions:

- start: IDLE to HIGH, on a data write.
- sample: HIGH to LOW, on half-period expiry, capturing MISO.
- launch: LOW to HIGH, on expiry when bits remain, driving the next MOSI bit.
- finish: LOW to IDLE, on expiry after the eighth bit, setting done and latching the received byte.

Top module: `spi_prescaled_master`

## Requirements
- R1: After reset, SCK is 0, MOSI is 0, `ss_n` is 1, the status register (address 1) reads 0 and the divider (address 2) reads 8.
- R2: A divider write (address 2) stores the written value with bit 0 cleared; if the result is below 8, the value 8 is stored instead. Examples: 5 reads back 8, 13 reads back 12, 20 reads back 20, 0 reads back 8.
- R3: SCK idles low. MOSI changes only on rising SCK edges and stays stable through each high phase. MISO is sampled on falling SCK edges.
- R4: A data write (address 0) in idle exchanges 8 bits MSB first. Afterwards, address 0 reads the byte received on MISO.
- R5: The SCK high and low phases each last divider/2 peripheral clocks. Done (status bit 0) becomes visible exactly 8×divider clocks after the starting write edge, at the end of the final low phase.
- R6: SCK rises on the same clock edge that accepts the starting data write.
- R7: Done clears when a status read made while done is 1 is followed by a data read. A data read without that prior status read leaves done set. A new transfer start also clears done.
- R8: A data write during a transfer sets the collision flag (status bit 1) and does not alter the byte being sent. The clearing sequence of R7 also clears the collision flag.
- R9: After a transfer, MOSI keeps the last bit sent until the next transfer starts.
- R10: Writing control (address 3) drives `ss_n` from bit 0 of the written value.
- R11: Status bit 2 (busy) is 1 from the start edge until the finish edge, and SCK is only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 divider, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Software-driven slave select |

## Verification
The bench builds the block with its default 8-bit data and divider widths and a minimum divider of 8. At run time it programs dividers of 8, 12 and 20, and also submits illegal values that must be coerced. The default widths let the bench count exact half-period lengths and total transfer latency in peripheral clocks for several prescaler settings, including the smallest legal one. A slave model drives MISO on rising edges and checks MOSI against a queue of expected bytes. This exercises all-zero, all-one and alternating patterns, as well as a collision injected mid-transfer.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } xfer_state_e;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DIV  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int STAT_DONE = 0;
    localparam int STAT_COLL = 1;
    localparam int STAT_BUSY = 2;
endpackage

// File: rtl/spi_div_guard.sv
module spi_div_guard #(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 8
) (
    input  logic [DIV_W-1:0] raw_div,
    output logic [DIV_W-1:0] legal_div
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] evened;

    always_comb begin
        evened    = {raw_div[DIV_W-1:1], 1'b0};
        legal_div = (evened < MIN_V) ? MIN_V : evened;
    end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half   = {1'b0, div[DIV_W-1:1]};
        expire = run && (cnt_q == half - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] sreg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg <= '0;
        else if (load)
            sreg <= load_val;
        else if (shift)
            sreg <= {sreg[W-2:0], sin};
    end
endmodule

// File: rtl/spi_prescaled_master.sv
module spi_prescaled_master #(
    parameter int DATA_W  = 8,
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    import spi_pm_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    xfer_state_e state_q, state_d;

    logic [CNT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  div_q, div_act_q, div_legal;
    logic [DATA_W-1:0] rx_q, sreg;
    logic              done_q, coll_q, arm_q;
    logic              busy_q;
    logic              expire;
    logic              data_wr, ctrl_wr, div_wr;
    logic              start, coll_evt, sample, launch, finish;
    logic              stat_rd, data_rd, other_acc, clear_seq;

    spi_div_guard #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_guard (
        .raw_div   (reg_wdata[DIV_W-1:0]),
        .legal_div (div_legal)
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy_q),
        .div    (div_act_q),
        .expire (expire)
    );

    spi_shift_unit #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (reg_wdata),
        .shift    (sample),
        .sin      (miso),
        .sreg     (sreg)
    );

    always_comb begin
        busy_q    = (state_q != ST_IDLE);
        data_wr   = reg_wr && (reg_addr == REG_DATA);
        ctrl_wr   = reg_wr && (reg_addr == REG_CTRL);
        div_wr    = reg_wr && (reg_addr == REG_DIV);
        stat_rd   = reg_rd && (reg_addr == REG_STAT);
        data_rd   = reg_rd && (reg_addr == REG_DATA);
        other_acc = (reg_rd || reg_wr) && (reg_addr[1] == 1'b1);
        clear_seq = data_rd && arm_q;
        start     = data_wr && (state_q == ST_IDLE);
        coll_evt  = data_wr && (state_q != ST_IDLE);
        sample    = (state_q == ST_HIGH) && expire;
        launch    = (state_q == ST_LOW) && expire && (bit_q != LAST_BIT);
        finish    = (state_q == ST_LOW) && expire && (bit_q == LAST_BIT);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)  state_d = ST_HIGH;
            ST_HIGH: if (sample) state_d = ST_LOW;
            ST_LOW: begin
                if (launch)      state_d = ST_HIGH;
                else if (finish) state_d = ST_IDLE;
            end
            default:             state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            mosi      <= 1'b0;
            bit_q     <= '0;
            rx_q      <= '0;
            done_q    <= 1'b0;
            coll_q    <= 1'b0;
            arm_q     <= 1'b0;
            ss_n      <= 1'b1;
            div_q     <= DIV_W'(MIN_DIV);
            div_act_q <= DIV_W'(MIN_DIV);
        end else begin
            if (start) begin
                sck       <= 1'b1;
                mosi      <= reg_wdata[DATA_W-1];
                bit_q     <= '0;
                div_act_q <= div_q;
            end else if (sample) begin
                sck <= 1'b0;
            end else if (launch) begin
                sck   <= 1'b1;
                mosi  <= sreg[DATA_W-1];
                bit_q <= bit_q + 1'b1;
            end

            if (finish)
                rx_q <= sreg;

            if (finish)
                done_q <= 1'b1;
            else if (start || clear_seq)
                done_q <= 1'b0;

            if (coll_evt)
                coll_q <= 1'b1;
            else if (clear_seq)
                coll_q <= 1'b0;

            if (stat_rd && done_q)
                arm_q <= 1'b1;
            else if (data_rd || other_acc || start)
                arm_q <= 1'b0;

            if (ctrl_wr)
                ss_n <= reg_wdata[0];
            if (div_wr)
                div_q <= div_legal;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_DATA: reg_rdata = rx_q;
            REG_STAT: begin
                reg_rdata[STAT_DONE] = done_q;
                reg_rdata[STAT_COLL] = coll_q;
                reg_rdata[STAT_BUSY] = busy_q;
            end
            REG_DIV:  reg_rdata = DATA_W'(div_q);
            REG_CTRL: reg_rdata[0] = ss_n;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sck,
    input logic mosi,
    input logic done,
    input logic coll,
    input logic data_wr,
    input logic ctrl_wr,
    input logic wbit0,
    input logic ss_n
);
    // R3
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(mosi));

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !sck));

    // R8
    collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr) |=> coll);

    // R10
    ssel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ss_n == $past(wbit0)));

    // R11
    sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy);
endmodule

bind spi_prescaled_master spi_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_q),
    .sck     (sck),
    .mosi    (mosi),
    .done    (done_q),
    .coll    (coll_q),
    .data_wr (data_wr),
    .ctrl_wr (ctrl_wr),
    .wbit0   (reg_wdata[0]),
    .ss_n    (ss_n)
);

// File: tb/sim_spi_prescaled_master.sv
module sim_spi_prescaled_master;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck, mosi, ss_n;
    logic       miso = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_tx[$];
    logic [7:0] slv_byte = 8'd0;

    spi_prescaled_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // slave model and scoreboard monitor
    initial begin
        logic [7:0] cap;
        logic       m_hi;
        logic [7:0] want;
        forever begin
            cap = 8'd0;
            for (int bi = 0; bi < 8; bi++) begin
                @(posedge sck);
                miso = slv_byte[7-bi];
                #1 m_hi = mosi;
                @(negedge sck);
                chk(m_hi == mosi, "R3 mosi stable in high phase", mosi, m_hi);
                cap = {cap[6:0], mosi};
            end
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R4 unexpected transfer", cap, 0);
            end else begin
                want = exp_tx.pop_front();
                chk(cap == want, "R4 byte seen by slave", cap, want);
            end
        end
    end

    // driver: one transfer with optional collision write
    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] slv,
                           input int div, input bit collide);
        int n;
        int hi;
        logic [7:0] v;
        slv_byte = slv;
        exp_tx.push_back(tx);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = tx; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        n = 1;
        hi = 0;
        chk(sck == 1'b1, "R6 sck rises on write edge", sck, 1);
        reg_addr = 2'd1;
        #1;
        chk(reg_rdata[2] == 1'b1, "R11 busy after start", reg_rdata[2], 1);
        forever begin
            if (sck) hi++;
            #1;
            if (reg_rdata[0]) break;
            if (collide && n == 10) begin
                reg_addr = 2'd0; reg_wdata = ~tx; reg_wr = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0; reg_addr = 2'd1;
                n++;
                continue;
            end
            @(negedge clk);
            n++;
            if (n > 4000) break;
        end
        chk(n == 8*div + 1, "R5 done latency in clocks", n, 8*div + 1);
        chk(hi == 4*div, "R5 sck high clocks", hi, 4*div);
        chk(reg_rdata[2] == 1'b0, "R11 busy clear at done", reg_rdata[2], 0);
        chk(reg_rdata[1] == collide, "R8 collision flag", reg_rdata[1], collide);
        rd_reg(2'd0, v);
        chk(v == slv, "R4 received byte", v, slv);
        chk(mosi == tx[0], "R9 mosi holds last bit", mosi, tx[0]);
        repeat (5) @(negedge clk);
        chk(mosi == tx[0] && sck == 1'b0, "R9 mosi still held, sck idle", mosi, tx[0]);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 chk(sck == 1'b0 && mosi == 1'b0, "R1 serial pins in reset", {sck, mosi}, 0);
        chk(ss_n == 1'b1, "R1 ss_n in reset", ss_n, 1);
        rst_n = 1'b1;
        rd_reg(2'd1, v); chk(v == 8'd0, "R1 status after reset", v, 0);
        rd_reg(2'd2, v); chk(v == 8'd8, "R1 divider after reset", v, 8);

        wr_reg(2'd2, 8'd5);  rd_reg(2'd2, v); chk(v == 8'd8,  "R2 divider 5", v, 8);
        wr_reg(2'd2, 8'd13); rd_reg(2'd2, v); chk(v == 8'd12, "R2 divider 13", v, 12);
        wr_reg(2'd2, 8'd20); rd_reg(2'd2, v); chk(v == 8'd20, "R2 divider 20", v, 20);
        wr_reg(2'd2, 8'd0);  rd_reg(2'd2, v); chk(v == 8'd8,  "R2 divider 0", v, 8);

        wr_reg(2'd3, 8'd0); #1 chk(ss_n == 1'b0, "R10 ss_n low", ss_n, 0);

        do_xfer(8'hA5, 8'h3C, 8, 1'b0);

        // R7: data read alone must not clear done
        rd_reg(2'd1, v); chk(v[0] == 1'b1, "R7 done still set", v[0], 1);
        wr_reg(2'd3, 8'd0);
        rd_reg(2'd0, v);
        rd_reg(2'd1, v); chk(v[0] == 1'b1, "R7 done kept without sequence", v[0], 1);
        rd_reg(2'd0, v);
        rd_reg(2'd1, v); chk(v[0] == 1'b0, "R7 done cleared by sequence", v[0], 0);

        wr_reg(2'd2, 8'd12);
        do_xfer(8'h81, 8'h7E, 12, 1'b0);

        wr_reg(2'd2, 8'd8);
        do_xfer(8'h5A, 8'hC3, 8, 1'b1);
        rd_reg(2'd1, v); chk(v[1] == 1'b1, "R8 collision persists", v[1], 1);
        rd_reg(2'd0, v);
        rd_reg(2'd1, v); chk(v[1:0] == 2'b00, "R8 collision cleared", v[1:0], 0);

        wr_reg(2'd2, 8'd20);
        do_xfer(8'h00, 8'hFF, 20, 1'b0);
        do_xfer(8'hFF, 8'h00, 20, 1'b0);
        rd_reg(2'd1, v); chk(v[0] == 1'b1, "R7 start clears prior done then sets", v[0], 1);

        wr_reg(2'd3, 8'd1); #1 chk(ss_n == 1'b1, "R10 ss_n high", ss_n, 1);
        repeat (4) @(negedge clk);
        chk(exp_tx.size() == 0, "R4 all queued bytes seen", exp_tx.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule